// File: doc/BRIEF.md
# Variable-Term Sum-of-Products Array

This block is a programmable AND-OR plane. It takes 22 logic signals and offers each one to the AND plane twice, once as-is and once inverted, for 44 literal columns. Every product-term row ANDs the literals that its fuses connect. The rows are then grouped. One row drives a global asynchronous-clear control and one drives a global synchronous-set control. Each of the ten outputs owns one output-enable row and a run of logic rows. The logic rows of an output are ORed into that output's sum.

The outputs do not all get the same number of logic terms. The two outer outputs get the fewest and the two middle outputs get the most, with the same pattern on both halves. All configuration arrives on one wide parallel fuse vector. The sums, the enables and the two global controls are captured in one output register stage, so the block hands clean, timed levels to the macrocells that follow it.

Top module: `sop_fuse_array`

## Requirements
- R1: All outputs are registered, with one clock of latency from `fuse_map`/`sig_in` to the outputs. An active-low asynchronous `rst_n` forces every output to 0 at once.
- R2: Literal column 2i carries `sig_in[i]` and column 2i+1 carries its inverse. The fuse for row r and column c is `fuse_map[44*r + c]`.
- R3: A fuse at 1 leaves its column out of the term. A row whose 44 fuses are all 1 gives a term value of 1, so a fully blank vector drives every output to 1.
- R4: A row that connects both columns of the same signal always evaluates to 0. An all-zero fuse vector drives every output to 0.
- R5: Row 0 (fuse bits 0..43) alone drives `async_clr_o`.
- R6: Row 131, the last row (fuse bits 5764..5807), alone drives `sync_set_o`.
- R7: Rows 1..130 are split into ten groups, one per output, in order of output index 0 to 9. The groups hold 8, 10, 12, 14, 16, 16, 14, 12, 10, 8 logic rows. Each group is led by one extra row that drives that output's `oe_o` bit, so output k's group starts at row 1 + the sum over j<k of (terms_j + 1).
- R8: `sum_o[k]` is the OR of the logic rows of group k only. The enable row and the rows of other groups have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| fuse_map | input | 5808 | Fuse vector, row-major, 44 bits per row |
| sig_in | input | 22 | Signals presented to the AND plane |
| sum_o | output | 10 | Registered OR of each output's logic terms |
| oe_o | output | 10 | Registered output-enable term of each output |
| async_clr_o | output | 1 | Registered global asynchronous-clear term |
| sync_set_o | output | 1 | Registered global synchronous-set term |

## Verification
The array is driven with single programmed rows against a background in which every other row is forced to 0. This shows whether a term lands on the right output bit: the clear control, the set control, an enable, or a sum. It also probes the first and last rows of several groups, which exposes off-by-one errors in the unequal group sizes. Matching and mismatching signal patterns, including patterns that use both polarities, separate correct literal polarity and column placement from swapped columns. Whole-vector patterns (all blank, all erased, and one contradictory row) test the default term values, and two-row groups test the OR across terms.

// File: rtl/sop_array_pkg.sv
package sop_array_pkg;

    localparam int unsigned DEF_NUM_SIG    = 22;
    localparam int unsigned DEF_NUM_OUT    = 10;
    localparam int unsigned DEF_BASE_TERMS = 8;
    localparam int unsigned DEF_TERM_STEP  = 2;

    // Logic terms granted to output k: smallest at the edges, mirrored.
    function automatic int unsigned logic_terms(int unsigned k, int unsigned num_out,
                                                int unsigned base, int unsigned step);
        int unsigned idx;
        idx = (k < num_out / 2) ? k : (num_out - 1 - k);
        return base + step * idx;
    endfunction

    // First row (the enable row) of output k's group; row 0 is the clear row.
    function automatic int unsigned group_base(int unsigned k, int unsigned num_out,
                                               int unsigned base, int unsigned step);
        int unsigned acc;
        acc = 1;
        for (int unsigned j = 0; j < k; j++) begin
            acc = acc + logic_terms(j, num_out, base, step) + 1;
        end
        return acc;
    endfunction

    // Rows in the whole plane: all groups plus the two global rows.
    function automatic int unsigned total_rows(int unsigned num_out,
                                               int unsigned base, int unsigned step);
        return group_base(num_out, num_out, base, step) + 1;
    endfunction

endpackage

// File: rtl/sop_literal_gen.sv
module sop_literal_gen #(
    parameter int unsigned NUM_SIG = 22,
    localparam int unsigned COLS   = 2 * NUM_SIG
) (
    input  logic [NUM_SIG-1:0] sig_i,
    output logic [COLS-1:0]    lit_o
);

    for (genvar i = 0; i < NUM_SIG; i++) begin : g_lit
        assign lit_o[2*i]   = sig_i[i];
        assign lit_o[2*i+1] = ~sig_i[i];
    end

endmodule

// File: rtl/sop_term_row.sv
module sop_term_row #(
    parameter int unsigned COLS = 44
) (
    input  logic [COLS-1:0] fuse_row_i,
    input  logic [COLS-1:0] lit_i,
    output logic            term_o
);

    // A blown fuse (1) masks its column out of the AND.
    assign term_o = &(fuse_row_i | lit_i);

endmodule

// File: rtl/sop_sum_group.sv
module sop_sum_group #(
    parameter int unsigned NUM_TERMS = 8
) (
    input  logic [NUM_TERMS-1:0] terms_i,
    output logic                 sum_o
);

    assign sum_o = |terms_i;

endmodule

// File: rtl/sop_fuse_array.sv
module sop_fuse_array
    import sop_array_pkg::*;
#(
    parameter int unsigned NUM_SIG    = DEF_NUM_SIG,
    parameter int unsigned NUM_OUT    = DEF_NUM_OUT,
    parameter int unsigned BASE_TERMS = DEF_BASE_TERMS,
    parameter int unsigned TERM_STEP  = DEF_TERM_STEP,
    localparam int unsigned COLS      = 2 * NUM_SIG,
    localparam int unsigned ROWS      = total_rows(NUM_OUT, BASE_TERMS, TERM_STEP),
    localparam int unsigned FUSE_W    = ROWS * COLS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FUSE_W-1:0]  fuse_map,
    input  logic [NUM_SIG-1:0] sig_in,
    output logic [NUM_OUT-1:0] sum_o,
    output logic [NUM_OUT-1:0] oe_o,
    output logic               async_clr_o,
    output logic               sync_set_o
);

    localparam int unsigned CLR_ROW = 0;
    localparam int unsigned SET_ROW = ROWS - 1;

    logic [COLS-1:0]    lits;
    logic [ROWS-1:0]    term_v;
    logic [NUM_OUT-1:0] sum_d;
    logic [NUM_OUT-1:0] oe_d;

    sop_literal_gen #(.NUM_SIG(NUM_SIG)) u_lits (
        .sig_i (sig_in),
        .lit_o (lits)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        sop_term_row #(.COLS(COLS)) u_row (
            .fuse_row_i (fuse_map[r*COLS +: COLS]),
            .lit_i      (lits),
            .term_o     (term_v[r])
        );
    end

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        localparam int unsigned GB = group_base(k, NUM_OUT, BASE_TERMS, TERM_STEP);
        localparam int unsigned NT = logic_terms(k, NUM_OUT, BASE_TERMS, TERM_STEP);
        assign oe_d[k] = term_v[GB];
        sop_sum_group #(.NUM_TERMS(NT)) u_sum (
            .terms_i (term_v[GB+1 +: NT]),
            .sum_o   (sum_d[k])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_o       <= '0;
            oe_o        <= '0;
            async_clr_o <= 1'b0;
            sync_set_o  <= 1'b0;
        end else begin
            sum_o       <= sum_d;
            oe_o        <= oe_d;
            async_clr_o <= term_v[CLR_ROW];
            sync_set_o  <= term_v[SET_ROW];
        end
    end

endmodule

// File: rtl/sop_fuse_array_chk.sv
module sop_fuse_array_chk #(
    parameter int unsigned COLS    = 44,
    parameter int unsigned FUSE_W  = 5808,
    parameter int unsigned NUM_OUT = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic [FUSE_W-1:0]  fuse_map,
    input logic [NUM_OUT-1:0] sum_o,
    input logic [NUM_OUT-1:0] oe_o,
    input logic               async_clr_o,
    input logic               sync_set_o
);

    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (sum_o == '0 && oe_o == '0 && !async_clr_o && !sync_set_o); // R1
        end
    end

    AST_ERASED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_map == '0) |=> (sum_o == '0 && oe_o == '0 && !async_clr_o && !sync_set_o)); // R4

    AST_BLANK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (&fuse_map) |=> (&sum_o && &oe_o && async_clr_o && sync_set_o)); // R3

    AST_CLR_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (&fuse_map[COLS-1:0]) |=> async_clr_o); // R5

    AST_SET_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (&fuse_map[FUSE_W-1 -: COLS]) |=> sync_set_o); // R6

    AST_CLR_CONTRA: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_map[1:0] == 2'b00) |=> !async_clr_o); // R4

endmodule

bind sop_fuse_array sop_fuse_array_chk #(
    .COLS    (COLS),
    .FUSE_W  (FUSE_W),
    .NUM_OUT (NUM_OUT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fuse_map    (fuse_map),
    .sum_o       (sum_o),
    .oe_o        (oe_o),
    .async_clr_o (async_clr_o),
    .sync_set_o  (sync_set_o)
);

// File: tb/sim_sop_fuse_array.sv
module sim_sop_fuse_array;

    localparam int CLK_PERIOD = 10;
    localparam int NSIG = 22;
    localparam int NOUT = 10;
    localparam int COLS = 44;
    localparam int ROWS = 132;
    localparam int FW   = ROWS * COLS;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [FW-1:0]   fuse;
    logic [NSIG-1:0] sig;
    logic [NOUT-1:0] sum_o, oe_o;
    logic            async_clr_o, sync_set_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sop_fuse_array u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .fuse_map    (fuse),
        .sig_in      (sig),
        .sum_o       (sum_o),
        .oe_o        (oe_o),
        .async_clr_o (async_clr_o),
        .sync_set_o  (sync_set_o)
    );

    typedef struct packed {
        logic [7:0]  row;
        logic [21:0] care;
        logic [21:0] val;
        logic [21:0] sv;
    } vec_t;

    // Single programmed row on a killed background.
    localparam vec_t VECS [14] = '{
        '{8'd0,   22'h000003, 22'h000001, 22'h000001},  // R5 clear row hit
        '{8'd0,   22'h000003, 22'h000001, 22'h000003},  // R5 clear row miss
        '{8'd131, 22'h000000, 22'h000000, 22'h155555},  // R6 set row blank
        '{8'd131, 22'h300000, 22'h100000, 22'h200000},  // R6 set row miss
        '{8'd1,   22'h200000, 22'h200000, 22'h200000},  // R2 enable of out0, top signal
        '{8'd1,   22'h000020, 22'h000020, 22'h000000},  // R2 true column of sig5, miss
        '{8'd2,   22'h3FFFFF, 22'h2AAAAA, 22'h2AAAAA},  // R7 first logic row out0
        '{8'd9,   22'h3FFFFF, 22'h155555, 22'h155555},  // R7 last logic row out0
        '{8'd10,  22'h000000, 22'h000000, 22'h000000},  // R7 enable out1
        '{8'd49,  22'h00000F, 22'h00000A, 22'h000005},  // R7 enable out4 miss
        '{8'd65,  22'h00000F, 22'h00000A, 22'h00000A},  // R7 last logic out4
        '{8'd66,  22'h000000, 22'h000000, 22'h000000},  // R7 enable out5
        '{8'd130, 22'h000001, 22'h000000, 22'h000000},  // R7 last logic out9 hit
        '{8'd122, 22'h000001, 22'h000000, 22'h000000}   // R7 enable out9
    };

    function automatic int out_terms(int k);
        return 8 + 2 * ((k < NOUT/2) ? k : (NOUT - 1 - k));
    endfunction

    function automatic int grp_start(int k);
        int s = 1;
        for (int j = 0; j < k; j++) s += out_terms(j) + 1;
        return s;
    endfunction

    // Expected {set, clr, oe[9:0], sum[9:0]} when only row r has value t.
    function automatic logic [21:0] row_effect(int r, logic t);
        logic [21:0] e = '0;
        if (r == 0) e[20] = t;
        else if (r == ROWS - 1) e[21] = t;
        else begin
            for (int k = 0; k < NOUT; k++) begin
                if (r == grp_start(k)) e[10+k] = t;
                else if (r > grp_start(k) && r <= grp_start(k) + out_terms(k)) e[k] = t;
            end
        end
        return e;
    endfunction

    function automatic logic term_val(logic [21:0] care, logic [21:0] val, logic [21:0] s);
        return &(~care | ~(s ^ val));
    endfunction

    task automatic kill_all();
        fuse = '1;
        for (int r = 0; r < ROWS; r++) begin
            fuse[r*COLS]     = 1'b0;
            fuse[r*COLS + 1] = 1'b0;
        end
    endtask

    task automatic prog_row(int r, logic [21:0] care, logic [21:0] val);
        for (int c = 0; c < COLS; c++) fuse[r*COLS + c] = 1'b1;
        for (int i = 0; i < NSIG; i++) begin
            if (care[i]) begin
                if (val[i]) fuse[r*COLS + 2*i] = 1'b0;
                else        fuse[r*COLS + 2*i + 1] = 1'b0;
            end
        end
    endtask

    task automatic check(string req, logic [21:0] exp);
        logic [21:0] got = {sync_set_o, async_clr_o, oe_o, sum_o};
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive at a falling edge, capture at the rising edge, sample at the next fall.
    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        fuse  = '1;
        sig   = '0;
        repeat (3) @(negedge clk);
        check("R1 reset state", 22'h000000);

        rst_n = 1'b1;
        settle();
        check("R3 blank array", 22'h3FFFFF);

        fuse = '0;
        settle();
        check("R4 erased array", 22'h000000);

        fuse = '1;
        fuse[3*2]     = 1'b0;
        fuse[3*2 + 1] = 1'b0;
        sig = 22'h000008;
        settle();
        check("R4 contradictory clear row", 22'h2FFFFF);

        for (int v = 0; v < 14; v++) begin
            kill_all();
            prog_row(int'(VECS[v].row), VECS[v].care, VECS[v].val);
            sig = VECS[v].sv;
            settle();
            check("R7 table row placement",
                  row_effect(int'(VECS[v].row), term_val(VECS[v].care, VECS[v].val, VECS[v].sv)));
        end

        // R8: two logic rows of out3 ORed; out3 enable row stays killed.
        kill_all();
        prog_row(grp_start(3) + 1, 22'h0000FF, 22'h00000F);
        prog_row(grp_start(3) + out_terms(3), 22'h0000FF, 22'h0000F0);
        sig = 22'h00000F;
        settle();
        check("R8 first term of out3", 22'h000008);
        sig = 22'h0000F0;
        settle();
        check("R8 last term of out3", 22'h000008);
        sig = 22'h000000;
        settle();
        check("R8 no term of out3", 22'h000000);

        // R1 latency: new input must not show before the next rising edge.
        @(negedge clk);
        sig = 22'h00000F;
        #1;
        check("R1 no early update", 22'h000000);
        @(negedge clk);
        check("R1 one-cycle update", 22'h000008);

        // R1 asynchronous reset mid-cycle.
        fuse = '1;
        settle();
        #1;
        rst_n = 1'b0;
        #1;
        check("R1 async clear", 22'h000000);
        @(negedge clk);
        rst_n = 1'b1;
        settle();
        check("R1 recovery after reset", 22'h3FFFFF);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule